// File: doc/BRIEF.md
# Configurable GPIO Port Controller

A 16-pin general-purpose I/O port whose pins are configured one by one through a small register bus. The bus has an address, write data, a write strobe and a read-data return that follows the address combinationally. Writes take effect at the clock edge. Each pin has five controls, all held in registers on that bus:

- a direction bit;
- an output latch bit;
- an open-drain bit;
- an analog-select bit;
- a port-wide enable for a dedicated pair of pins.

The block drives per-pin output data and output-enable toward the pads and takes the pad input levels back in.

The sensed value of each pin is built in three steps. The pad input passes through a two-flop synchronizer. It is then combined with the level the pin itself drives, and gated by the analog-select and pair-enable controls. The result is captured in a single port-read register. Because of that register, software sees any change of direction or latch one clock after the register write has landed. A change at a pad appears after three edges.

Top module: `gpio_port_ctrl`

## Requirements
- R1: Register map, one bit per pin at bit position i: 0 = direction (1 = input, 0 = output), 1 = output latch, 2 = pin-sense (a read returns the sensed pins, a write loads the output latch), 3 = open-drain enable, 4 = analog select, 5 = pair enable (bit 0 only, upper bits read 0). Addresses 6 and 7 read 0, and writes to them change no register.
- R2: A pin with direction 1 has pad_oe low. A pin with direction 0 and open-drain 0 has pad_oe high and pad_out equal to its latch bit.
- R3: A pin with direction 0 and open-drain 1 never drives high. With latch 1 it has pad_oe low. With latch 0 it has pad_oe high and pad_out 0. Its pad_oe is therefore the inverse of its latch bit.
- R4: A pin with analog select 1 reads 0 at the pin-sense address, whatever its pad or driven level.
- R5: Pins 2 and 3 read 0 at the pin-sense address until pair-enable bit 0 is 1.
- R6: A write to address 1 or to address 2 updates the output latch. A read of address 1 returns the latch, not the pad.
- R7: After reset, direction and analog select are all 1, and latch, open-drain, pair enable and pin-sense are all 0.
- R8: A pin whose driver is enabled senses its own driven level. A pin whose driver is off senses the synchronized pad level.
- R9: After a write edge that changes direction or latch, the pin-sense read still shows the old value in the following cycle and the new value from the second cycle on. A pad change is visible after the third rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register select |
| bus_wdata | input | 16 | Write data |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_rdata | output | 16 | Read data for bus_addr |
| pad_in | input | 16 | Pad input levels |
| pad_out | output | 16 | Pad output data |
| pad_oe | output | 16 | Pad output enable, 1 = drive |

## Verification
A corrupted control register shows at once on pad_oe or pad_out for any pin configured as an output. For an input pin it shows only through the pin-sense read, and only one cycle after the fault, because of the capture register. A lost synchronizer stage or a missing capture stage shifts visibility by one cycle. Directed reads placed exactly at the first and second cycle after a write or pad change expose it. Gating faults in the analog or pair-enable paths show as nonzero bits where the configuration forces zero.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        SEL_DIR  = 3'd0,
        SEL_LAT  = 3'd1,
        SEL_PIN  = 3'd2,
        SEL_ODE  = 3'd3,
        SEL_ANA  = 3'd4,
        SEL_CFG  = 3'd5,
        SEL_RSV6 = 3'd6,
        SEL_RSV7 = 3'd7
    } reg_sel_e;
endpackage

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  wdata,
    input  logic [WIDTH-1:0]  sensed,
    output logic [WIDTH-1:0]  dir_q,
    output logic [WIDTH-1:0]  lat_q,
    output logic [WIDTH-1:0]  ode_q,
    output logic [WIDTH-1:0]  ana_q,
    output logic              cfg_en,
    output logic [WIDTH-1:0]  rdata
);
    reg_sel_e sel;
    assign sel = reg_sel_e'(addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q  <= '1;
            lat_q  <= '0;
            ode_q  <= '0;
            ana_q  <= '1;
            cfg_en <= 1'b0;
        end else if (we) begin
            unique case (sel)
                SEL_DIR:          dir_q  <= wdata;
                SEL_LAT, SEL_PIN: lat_q  <= wdata;
                SEL_ODE:          ode_q  <= wdata;
                SEL_ANA:          ana_q  <= wdata;
                SEL_CFG:          cfg_en <= wdata[0];
                default:          ;
            endcase
        end
    end

    always_comb begin
        unique case (sel)
            SEL_DIR: rdata = dir_q;
            SEL_LAT: rdata = lat_q;
            SEL_PIN: rdata = sensed;
            SEL_ODE: rdata = ode_q;
            SEL_ANA: rdata = ana_q;
            SEL_CFG: rdata = {{(WIDTH-1){1'b0}}, cfg_en};
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] lat_q,
    input  logic [WIDTH-1:0] ode_q,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        logic is_out;
        assign is_out = ~dir_q[i];
        // open-drain pins only ever pull low
        assign pad_out[i] = ode_q[i] ? 1'b0 : lat_q[i];
        assign pad_oe[i]  = is_out & ~(ode_q[i] & lat_q[i]);
    end
endmodule

// File: rtl/gpio_input_path.sv
module gpio_input_path #(
    parameter int WIDTH       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int PAIR_LO     = 2,
    parameter int PAIR_HI     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pad_in,
    input  logic [WIDTH-1:0] pad_out,
    input  logic [WIDTH-1:0] pad_oe,
    input  logic [WIDTH-1:0] ana_q,
    input  logic             cfg_en,
    output logic [WIDTH-1:0] port_q
);
    logic [WIDTH-1:0] sync_r [SYNC_STAGES];
    logic [WIDTH-1:0] level;
    logic [WIDTH-1:0] gated;

    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_r[s] <= '0;
            else if (s == 0) sync_r[s] <= pad_in;
            else sync_r[s] <= sync_r[(s == 0) ? 0 : s-1];
        end
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_gate
        logic pair_pin;
        assign pair_pin = (i == PAIR_LO) || (i == PAIR_HI);
        assign level[i] = pad_oe[i] ? pad_out[i] : sync_r[SYNC_STAGES-1][i];
        assign gated[i] = level[i] & ~ana_q[i] & (~pair_pin | cfg_en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) port_q <= '0;
        else        port_q <= gated;
    end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_pkg::*;
#(
    parameter int WIDTH       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int PAIR_LO     = 2,
    parameter int PAIR_HI     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    input  logic              bus_we,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pad_in,
    output logic [WIDTH-1:0]  pad_out,
    output logic [WIDTH-1:0]  pad_oe
);
    logic [WIDTH-1:0] dir_q, lat_q, ode_q, ana_q, port_q;
    logic             cfg_en;

    gpio_regfile #(.WIDTH(WIDTH)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr),
        .wdata(bus_wdata), .sensed(port_q), .dir_q(dir_q), .lat_q(lat_q),
        .ode_q(ode_q), .ana_q(ana_q), .cfg_en(cfg_en), .rdata(bus_rdata)
    );

    gpio_pin_drive #(.WIDTH(WIDTH)) u_drive (
        .dir_q(dir_q), .lat_q(lat_q), .ode_q(ode_q),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    gpio_input_path #(
        .WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES),
        .PAIR_LO(PAIR_LO), .PAIR_HI(PAIR_HI)
    ) u_in (
        .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .ana_q(ana_q), .cfg_en(cfg_en), .port_q(port_q)
    );
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
    import gpio_pkg::*;
#(
    parameter int WIDTH   = 16,
    parameter int PAIR_LO = 2,
    parameter int PAIR_HI = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [WIDTH-1:0]  bus_wdata,
    input logic              bus_we,
    input logic [WIDTH-1:0]  bus_rdata,
    input logic [WIDTH-1:0]  pad_out,
    input logic [WIDTH-1:0]  pad_oe,
    input logic [WIDTH-1:0]  dir_q,
    input logic [WIDTH-1:0]  lat_q,
    input logic [WIDTH-1:0]  ode_q,
    input logic [WIDTH-1:0]  ana_q,
    input logic              cfg_en
);
    assert_input_no_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & dir_q) == '0);

    assert_od_never_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & pad_out & ode_q) == '0);

    assert_analog_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == SEL_PIN) |-> ((bus_rdata & $past(ana_q)) == '0));

    assert_pair_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == SEL_PIN && !$past(cfg_en)) |->
            (bus_rdata[PAIR_LO] == 1'b0 && bus_rdata[PAIR_HI] == 1'b0));

    assert_latch_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && (bus_addr == SEL_LAT || bus_addr == SEL_PIN)) |=>
            (lat_q == $past(bus_wdata)));
endmodule

bind gpio_port_ctrl gpio_port_chk #(.WIDTH(WIDTH), .PAIR_LO(PAIR_LO), .PAIR_HI(PAIR_HI)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .pad_out(pad_out), .pad_oe(pad_oe),
    .dir_q(dir_q), .lat_q(lat_q), .ode_q(ode_q), .ana_q(ana_q), .cfg_en(cfg_en)
);

// File: tb/sim_gpio_port_ctrl.sv
module sim_gpio_port_ctrl;
    localparam int W = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    bus_addr = '0;
    logic [W-1:0]  bus_wdata = '0;
    logic          bus_we = 1'b0;
    logic [W-1:0]  bus_rdata;
    logic [W-1:0]  pad_in = '0;
    logic [W-1:0]  pad_out, pad_oe;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [W-1:0] m_dir, m_lat, m_ode, m_ana;
    logic         m_cfg;

    gpio_port_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // write: drive at negedge, captured at next posedge, ends at the negedge after it
    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        case (a)
            3'd0: m_dir = d;
            3'd1, 3'd2: m_lat = d;
            3'd3: m_ode = d;
            3'd4: m_ana = d;
            3'd5: m_cfg = d[0];
            default: ;
        endcase
    endtask

    task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    function automatic logic [W-1:0] exp_oe();
        return ~m_dir & ~(m_ode & m_lat);
    endfunction

    function automatic logic [W-1:0] exp_out();
        return m_lat & ~m_ode;
    endfunction

    function automatic logic [W-1:0] exp_pin(input logic [W-1:0] pads);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) begin
            r[i] = exp_oe()[i] ? exp_out()[i] : pads[i];
            if (m_ana[i]) r[i] = 1'b0;
            if ((i == 2 || i == 3) && !m_cfg) r[i] = 1'b0;
        end
        return r;
    endfunction

    task automatic check_all_regs(input string req);
        logic [W-1:0] v;
        rd(3'd0, v); check({req, " dir"}, v, m_dir);
        rd(3'd1, v); check({req, " lat"}, v, m_lat);
        rd(3'd3, v); check({req, " ode"}, v, m_ode);
        rd(3'd4, v); check({req, " ana"}, v, m_ana);
        rd(3'd5, v); check({req, " cfg"}, v, {{(W-1){1'b0}}, m_cfg});
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] v;
        void'($urandom(32'd2024));
        m_dir = '1; m_lat = '0; m_ode = '0; m_ana = '1; m_cfg = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R7 reset state
        check_all_regs("R7 reset");
        rd(3'd2, v); check("R7 reset pin-sense", v, '0);
        check("R7 reset oe", pad_oe, '0);

        // R1 reserved addresses read 0 and ignore writes
        wr(3'd6, 16'hFFFF); wr(3'd7, 16'h1234);
        m_dir = '1; m_lat = '0; m_ode = '0; m_ana = '1; m_cfg = 1'b0;
        rd(3'd6, v); check("R1 rsv6 read", v, '0);
        rd(3'd7, v); check("R1 rsv7 read", v, '0);
        check_all_regs("R1 rsv write ignored");

        // R9 pad latency: visible only after third edge
        wr(3'd4, 16'h0000); wr(3'd5, 16'h0001);
        pad_in = 16'h0000;
        repeat (4) @(negedge clk);
        pad_in = 16'h0001;
        @(negedge clk); @(negedge clk);
        rd(3'd2, v); check("R9 pad after 2 edges old", v & 16'h0001, 16'h0000);
        @(negedge clk);
        rd(3'd2, v); check("R9 pad after 3 edges new", v & 16'h0001, 16'h0001);

        // R9 direction change: old in next cycle, new from the second cycle
        pad_in = 16'h0000; wr(3'd1, 16'h0001);
        repeat (4) @(negedge clk);
        rd(3'd2, v); check("R9 input before dir change", v & 16'h0001, 16'h0000);
        wr(3'd0, 16'hFFFE);
        rd(3'd2, v); check("R9 dir first cycle old", v & 16'h0001, 16'h0000);
        @(negedge clk);
        rd(3'd2, v); check("R9 dir second cycle new R8", v & 16'h0001, 16'h0001);

        // R6 write through pin-sense address loads latch; lat read is latch not pad
        wr(3'd2, 16'h0000);
        rd(3'd2, v); check("R9 latch first cycle old", v & 16'h0001, 16'h0001);
        @(negedge clk);
        rd(3'd2, v); check("R9 latch second cycle new", v & 16'h0001, 16'h0000);
        pad_in = 16'hFFFF; wr(3'd0, 16'hFFFF); repeat (4) @(negedge clk);
        rd(3'd1, v); check("R6 lat read independent of pad", v, 16'h0000);

        // R3 open-drain oe follows inverse of latch
        wr(3'd0, 16'h0000); wr(3'd3, 16'hFFFF); wr(3'd1, 16'hA5C3);
        check("R3 od oe", pad_oe, ~16'hA5C3);
        check("R3 od out", pad_out, 16'h0000);

        // R5 pair gating, R4 analog
        wr(3'd0, 16'hFFFF); wr(3'd3, 16'h0000); wr(3'd5, 16'h0000);
        wr(3'd4, 16'h00F0); pad_in = 16'hFFFF;
        repeat (4) @(negedge clk);
        rd(3'd2, v); check("R5 R4 gated read", v, 16'hFF03);
        wr(3'd5, 16'h0001); @(negedge clk);
        rd(3'd2, v); check("R5 enabled read", v, 16'hFF0F);

        // constrained random sweep
        for (int it = 0; it < 300; it++) begin
            wr(3'd0, W'($urandom));
            wr(3'($urandom_range(1, 2)), W'($urandom));
            wr(3'd3, W'($urandom) & W'($urandom));
            wr(3'd4, W'($urandom) & W'($urandom));
            wr(3'd5, W'($urandom));
            if ((it % 7) == 0) wr(3'($urandom_range(6, 7)), W'($urandom));
            pad_in = W'($urandom);
            repeat (4) @(negedge clk);
            check("R2 R3 rand oe", pad_oe, exp_oe());
            check("R2 rand out", pad_out & pad_oe, exp_out() & exp_oe());
            rd(3'd2, v); check("R4 R5 R8 rand pin", v, exp_pin(pad_in));
            if ((it % 10) == 0) check_all_regs("R1 R6 rand regs");
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule